// File: doc/BRIEF.md
# Autoincrement Address and Loop-Counter Unit

This unit holds the two memory pointers and the loop counter of a small 16-bit stack machine. A source pointer supplies the address of every memory read and steps forward by one word after each use. A destination pointer does the same for every memory write. Together they let a block copy run as a plain read/write sequence, with no separate increment instructions.

A third register counts loop passes. A fused decrement-and-test strobe lowers the counter by one and raises a branch signal in the same cycle when the new value is not zero. The surrounding core uses that signal to take the loop's backward jump. Any of the three registers can be loaded from the data-stack top, and any of them can be read back through one selectable output for a push onto the stack. Memory is addressed in 16-bit words over a 64K-word space. The memory itself and all program-counter arithmetic sit outside this unit.

Top module: `addr_loop_unit`

## Requirements
- R1: After reset the source pointer, destination pointer and counter are all 0, and readReq, writeReq and branchTaken are low.
- R2: A load strobe (loadSrc, loadDst, loadCnt) writes stackTop into its register at the clock edge. regOut shows the register chosen by outSel (0 = source, 1 = destination, 2 = counter, 3 = constant 0) in the same cycle.
- R3: While srcRead is high, readReq is high and readAddr equals the current source pointer in that cycle. After the edge the source pointer is one higher.
- R4: While dstWrite is high, writeReq is high and writeAddr equals the current destination pointer in that cycle. After the edge the destination pointer is one higher.
- R5: Every pointer increment and counter decrement wraps modulo 2^16. 0xFFFF steps to 0x0000, and 0x0000 decrements to 0xFFFF.
- R6: While loopDec is high, branchTaken is high in the same cycle exactly when counter minus 1 is not zero. After the edge the counter holds counter minus 1.
- R7: A counter loaded with N (1 to 65535) gives N-1 taken branches before the first not-taken one. A counter loaded with 0 gives 65535 taken branches, so the loop runs 65536 passes.
- R8: A load strobe wins over a step on the same register in the same cycle. The register takes stackTop with no increment or decrement, and a loopDec that coincides with loadCnt gives no branch. readReq and writeReq still follow srcRead and dstWrite.
- R9: A register with no strobe keeps its value. A read step and a write step in the same cycle each advance only their own pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| stackTop | input | 16 | Data-stack top value for loads |
| loadSrc | input | 1 | Load source pointer from stackTop |
| loadDst | input | 1 | Load destination pointer from stackTop |
| loadCnt | input | 1 | Load loop counter from stackTop |
| srcRead | input | 1 | Memory read through source pointer, then post-increment |
| dstWrite | input | 1 | Memory write through destination pointer, then post-increment |
| loopDec | input | 1 | Decrement counter and test for non-zero |
| outSel | input | 2 | Register shown on regOut |
| regOut | output | 16 | Selected register value for a push to the stack |
| readReq | output | 1 | Memory read request |
| readAddr | output | 16 | Memory read word address |
| writeReq | output | 1 | Memory write request |
| writeAddr | output | 16 | Memory write word address |
| branchTaken | output | 1 | Decrement-and-branch result: take the branch |

## Verification
The hardest case to reach is the 65536-pass loop that starts from a counter loaded with zero. It takes an unbroken run of 65536 decrements, so the bench drives loopDec every cycle and counts taken branches until the first not-taken one. The pointer wrap past 0xFFFF is reached directly by loading 0xFFFF, without stepping through the whole space. Coincident load-and-step cycles are driven on purpose for every register to show that the load wins.

// File: rtl/alu_ptr_pkg.sv
package alu_ptr_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic ldSrc;
    logic ldDst;
    logic ldCnt;
    logic incSrc;
    logic incDst;
    logic decCnt;
  } ptrStrobe_t;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_ZERO = 2'd3
  } outSel_e;
endpackage

// File: rtl/alu_ptr_ctrl.sv
module alu_ptr_ctrl
  import alu_ptr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadSrc,
  input  logic       loadDst,
  input  logic       loadCnt,
  input  logic       srcRead,
  input  logic       dstWrite,
  input  logic       loopDec,
  input  logic       cntIsOne,
  output ptrStrobe_t strb,
  output logic       readReq,
  output logic       writeReq,
  output logic       branchTaken
);
  always_comb begin
    strb.ldSrc  = loadSrc;
    strb.ldDst  = loadDst;
    strb.ldCnt  = loadCnt;
    strb.incSrc = srcRead & ~loadSrc;
    strb.incDst = dstWrite & ~loadDst;
    strb.decCnt = loopDec & ~loadCnt;
  end

  assign readReq     = srcRead;
  assign writeReq    = dstWrite;
  assign branchTaken = strb.decCnt & ~cntIsOne;

  // R8: no branch while a counter load is in progress
  a_r8_no_branch_on_load: assert property (@(posedge clk) disable iff (!rstN)
    loadCnt |-> !branchTaken);
  // R6: a branch needs a decrement request
  a_r6_branch_needs_dec: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> loopDec);
endmodule

// File: rtl/alu_ptr_datapath.sv
module alu_ptr_datapath
  import alu_ptr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptrStrobe_t        strb,
  input  logic [DATA_W-1:0] stackTop,
  input  logic [1:0]        outSel,
  output logic [DATA_W-1:0] srcPtr,
  output logic [DATA_W-1:0] dstPtr,
  output logic [DATA_W-1:0] regOut,
  output logic              cntIsOne
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] srcReg, dstReg, cntReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg <= '0;
      dstReg <= '0;
      cntReg <= '0;
    end else begin
      if (strb.ldSrc)       srcReg <= stackTop;
      else if (strb.incSrc) srcReg <= srcReg + ONE;
      if (strb.ldDst)       dstReg <= stackTop;
      else if (strb.incDst) dstReg <= dstReg + ONE;
      if (strb.ldCnt)       cntReg <= stackTop;
      else if (strb.decCnt) cntReg <= cntReg - ONE;
    end
  end

  assign srcPtr   = srcReg;
  assign dstPtr   = dstReg;
  assign cntIsOne = (cntReg == ONE);

  always_comb begin
    unique case (outSel_e'(outSel))
      SEL_SRC: regOut = srcReg;
      SEL_DST: regOut = dstReg;
      SEL_CNT: regOut = cntReg;
      default: regOut = '0;
    endcase
  end

  // R2, R8: a load takes stackTop
  a_r2_src_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldSrc |=> srcReg == $past(stackTop));
  a_r2_cnt_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldCnt |=> cntReg == $past(stackTop));
  // R3, R5: source post-increment with wrap
  a_r3_src_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incSrc && !strb.ldSrc) |=> srcReg == $past(srcReg) + ONE);
  // R4: destination post-increment
  a_r4_dst_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incDst && !strb.ldDst) |=> dstReg == $past(dstReg) + ONE);
  // R6: counter decrement
  a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decCnt && !strb.ldCnt) |=> cntReg == $past(cntReg) - ONE);
  // R9: idle registers hold
  a_r9_dst_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ldDst && !strb.incDst) |=> $stable(dstReg));
  a_r9_cnt_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ldCnt && !strb.decCnt) |=> $stable(cntReg));
endmodule

// File: rtl/addr_loop_unit.sv
module addr_loop_unit
  import alu_ptr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] stackTop,
  input  logic              loadSrc,
  input  logic              loadDst,
  input  logic              loadCnt,
  input  logic              srcRead,
  input  logic              dstWrite,
  input  logic              loopDec,
  input  logic [1:0]        outSel,
  output logic [DATA_W-1:0] regOut,
  output logic              readReq,
  output logic [DATA_W-1:0] readAddr,
  output logic              writeReq,
  output logic [DATA_W-1:0] writeAddr,
  output logic              branchTaken
);
  ptrStrobe_t strb;
  logic       cntIsOne;

  alu_ptr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .loadSrc(loadSrc), .loadDst(loadDst), .loadCnt(loadCnt),
    .srcRead(srcRead), .dstWrite(dstWrite), .loopDec(loopDec),
    .cntIsOne(cntIsOne), .strb(strb),
    .readReq(readReq), .writeReq(writeReq), .branchTaken(branchTaken)
  );

  alu_ptr_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stackTop(stackTop),
    .outSel(outSel), .srcPtr(readAddr), .dstPtr(writeAddr),
    .regOut(regOut), .cntIsOne(cntIsOne)
  );
endmodule

// File: tb/test_addr_loop_unit.sv
module test_addr_loop_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] stackTop = '0;
  logic        loadSrc = 0, loadDst = 0, loadCnt = 0;
  logic        srcRead = 0, dstWrite = 0, loopDec = 0;
  logic [1:0]  outSel = 2'd0;
  logic [15:0] regOut, readAddr, writeAddr;
  logic        readReq, writeReq, branchTaken;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  addr_loop_unit i_addr_loop_unit (
    .clk(clk), .rstN(rstN), .stackTop(stackTop),
    .loadSrc(loadSrc), .loadDst(loadDst), .loadCnt(loadCnt),
    .srcRead(srcRead), .dstWrite(dstWrite), .loopDec(loopDec),
    .outSel(outSel), .regOut(regOut),
    .readReq(readReq), .readAddr(readAddr),
    .writeReq(writeReq), .writeAddr(writeAddr),
    .branchTaken(branchTaken)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    loadSrc = 0; loadDst = 0; loadCnt = 0;
    srcRead = 0; dstWrite = 0; loopDec = 0;
  endtask

  // one clock edge, then settle
  task automatic tick();
    @(posedge clk); #1;
    idle();
    #0.5;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [15:0] v);
    outSel = sel; #0.5; v = regOut;
  endtask

  task automatic loadReg(input int which, input logic [15:0] v);
    stackTop = v;
    if (which == 0) loadSrc = 1;
    else if (which == 1) loadDst = 1;
    else loadCnt = 1;
    tick();
  endtask

  initial begin
    #200000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int branches;
    #5 rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    peek(2'd0, v); chk("R1 src", v, 0);
    peek(2'd1, v); chk("R1 dst", v, 0);
    peek(2'd2, v); chk("R1 cnt", v, 0);
    chk("R1 req", {readReq, writeReq, branchTaken}, 0);

    // R2 loads and outSel sweep
    for (int k = 0; k < 16; k++) begin
      logic [15:0] a, b, c;
      a = 16'(k * 4099 + 7); b = 16'(k * 257 + 3); c = 16'(k * 31 + 1);
      loadReg(0, a); loadReg(1, b); loadReg(2, c);
      peek(2'd0, v); chk("R2 src", v, a);
      peek(2'd1, v); chk("R2 dst", v, b);
      peek(2'd2, v); chk("R2 cnt", v, c);
      peek(2'd3, v); chk("R2 zero", v, 0);
    end

    // R3/R4/R9: block copy with start addresses swept
    for (int k = 0; k < 8; k++) begin
      logic [15:0] s0, d0;
      s0 = 16'(k * 1000 + 5); d0 = 16'(k * 777 + 9000);
      loadReg(0, s0); loadReg(1, d0);
      for (int j = 0; j < 10; j++) begin
        srcRead = 1; dstWrite = (j % 3 != 2); #0.5;
        chk("R3 readReq", readReq, 1);
        chk("R3 readAddr", readAddr, 16'(s0 + j));
        chk("R4 writeReq", writeReq, dstWrite);
        tick();
      end
      peek(2'd0, v); chk("R3 src after", v, 16'(s0 + 10));
      peek(2'd1, v); chk("R9 dst after", v, 16'(d0 + 7));
      tick();
      peek(2'd0, v); chk("R9 src hold", v, 16'(s0 + 10));
    end
    loadReg(1, 16'h0100);
    dstWrite = 1; #0.5;
    chk("R4 writeAddr", writeAddr, 16'h0100);
    chk("R4 writeReq", writeReq, 1);
    tick();
    peek(2'd1, v); chk("R4 dst step", v, 16'h0101);

    // R5 wrap
    loadReg(0, 16'hFFFF); srcRead = 1; tick();
    peek(2'd0, v); chk("R5 src wrap", v, 16'h0000);
    loadReg(1, 16'hFFFF); dstWrite = 1; tick();
    peek(2'd1, v); chk("R5 dst wrap", v, 16'h0000);
    loadReg(2, 16'h0000); loopDec = 1; #0.5;
    chk("R5 branch from 0", branchTaken, 1);
    tick();
    peek(2'd2, v); chk("R5 cnt wrap", v, 16'hFFFF);

    // R6/R7 loop counts for small N
    for (int n = 1; n <= 20; n++) begin
      loadReg(2, 16'(n));
      branches = 0;
      for (int j = 0; j < n; j++) begin
        loopDec = 1; #0.5;
        if (branchTaken) branches++;
        if (j == n - 1) chk("R6 last not taken", branchTaken, 0);
        tick();
      end
      chk("R7 branch count", branches, n - 1);
      peek(2'd2, v); chk("R6 cnt end", v, 0);
    end

    // R7 counter loaded with 0: 65536 passes
    loadReg(2, 16'h0000);
    branches = 0;
    for (int j = 0; j < 70000; j++) begin
      loopDec = 1; #0.5;
      if (!branchTaken) begin
        tick();
        break;
      end
      branches++;
      tick();
    end
    chk("R7 zero-load branches", branches, 65535);

    // R8 load wins over step
    loadReg(0, 16'h1234);
    stackTop = 16'h4000; loadSrc = 1; srcRead = 1; #0.5;
    chk("R8 readReq still", readReq, 1);
    tick();
    peek(2'd0, v); chk("R8 src load wins", v, 16'h4000);
    stackTop = 16'h5000; loadDst = 1; dstWrite = 1; tick();
    peek(2'd1, v); chk("R8 dst load wins", v, 16'h5000);
    loadReg(2, 16'h0009);
    stackTop = 16'h0030; loadCnt = 1; loopDec = 1; #0.5;
    chk("R8 no branch", branchTaken, 0);
    tick();
    peek(2'd2, v); chk("R8 cnt load wins", v, 16'h0030);

    // R9 idle cycles hold all
    for (int j = 0; j < 4; j++) tick();
    peek(2'd0, v); chk("R9 src idle", v, 16'h4000);
    peek(2'd1, v); chk("R9 dst idle", v, 16'h5000);
    peek(2'd2, v); chk("R9 cnt idle", v, 16'h0030);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule